// File: doc/BRIEF.md
# Graphics Request Protocol Checker

This block watches the request stream that a graphics card presents to the port and flags protocol violations as they happen. Each cycle in which a request strobe is high, it looks at the request's signalling mode (pipelined or sideband), the sideband-enable setting, the upper bits of the 64-bit request address and the 4-bit command code. It also tracks how many transactions are in flight, counting each accepted request up and each completion strobe down, against a fixed limit of 16.

Four sticky error flags record mode mixing, an address outside the legal range, a request arriving while the queue is full, and an undefined command. Software clears each flag by writing a one to its clear bit. A request that would overflow the queue or carries an undefined command is refused at `reqAccept` and leaves the count untouched. Mode-mix and address errors are recorded, but the request is still accepted.

Top module: `agp_req_checker`

## Requirements
- R1: A request with `reqPipe`=1 while `sbEnable`=1 sets `errModeMix` at the next clock edge. A pipelined request with sideband disabled, or a sideband request (`reqPipe`=0), leaves the flag alone.
- R2: A request with any of address bits 63..40 set sets `errAddr` at the next edge. An address with only bits 39..0 set does not.
- R3: A request that arrives while `outstanding` is 16 sets `errOverflow`, is refused (`reqAccept`=0) and does not increment the count. This holds even if a completion arrives in the same cycle.
- R4: The legal command codes are 4'h0 (read), 4'h1 (high-priority read), 4'h4 (write) and 4'h5 (high-priority write). Any other code sets `errIllegalCmd`, and the request is refused.
- R5: `outstanding` increments on an accepted request, decrements on a completion, and holds when both occur in the same cycle.
- R6: A completion while `outstanding` is 0 has no effect; the count stays at 0.
- R7: The error flags are sticky. Bit positions of `clrErr` are [0] mode mix, [1] address, [2] overflow and [3] illegal command. Writing a one clears only that flag. If a new error and a clear for the same flag fall in one cycle, the flag stays set.
- R8: `reqAccept` is combinational within the request cycle. A request with only mode-mix or address errors is still accepted and counted.
- R9: After reset, all four flags are 0 and `outstanding` is 0.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe from the card |
| reqPipe | input | 1 | 1 = pipelined request, 0 = sideband request |
| sbEnable | input | 1 | Sideband addressing enabled |
| reqAddr | input | 64 | Request address |
| reqCmd | input | 4 | Request command code |
| cplValid | input | 1 | Completion strobe, retires one transaction |
| clrErr | input | 4 | Write-one-to-clear for the error flags |
| reqAccept | output | 1 | Request accepted this cycle |
| outstanding | output | 5 | Transactions in flight |
| errModeMix | output | 1 | Sticky mode-mix error |
| errAddr | output | 1 | Sticky address-range error |
| errOverflow | output | 1 | Sticky queue-overflow error |
| errIllegalCmd | output | 1 | Sticky illegal-command error |

## Verification
The mode check is driven with all three non-error combinations of mode and enable, alongside the erroring one. This shows that the flag depends on both signals together. Addresses are tried just below bit 40, exactly at bit 40 and at bit 63, which places the range boundary. Commands cover legal and illegal codes, which separates refusal from mere flagging. The counter is filled to the limit and pushed past it, both with and without a simultaneous completion, and then drained past zero. Together these tell apart the full, near-full and empty corners.

// File: rtl/agp_chk_pkg.sv
package agp_chk_pkg;
  localparam int NUM_ERR = 4;
  localparam int ERR_MODE = 0;
  localparam int ERR_ADDR = 1;
  localparam int ERR_OVF  = 2;
  localparam int ERR_CMD  = 3;

  typedef enum logic [3:0] {
    CMD_READ    = 4'h0,
    CMD_HP_READ = 4'h1,
    CMD_WRITE   = 4'h4,
    CMD_HP_WRITE = 4'h5
  } cmd_e;

  typedef struct packed {
    logic accept;
    logic retire;
    logic [NUM_ERR-1:0] errSet;
  } chkStrobes_t;

  function automatic logic isLegalCmd(input logic [3:0] code);
    case (code)
      CMD_READ, CMD_HP_READ, CMD_WRITE, CMD_HP_WRITE: isLegalCmd = 1'b1;
      default: isLegalCmd = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/agp_chk_ctrl.sv
module agp_chk_ctrl
  import agp_chk_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int LEGAL_W = 40,
  parameter int MAX_OUT = 16,
  localparam int CNT_W  = $clog2(MAX_OUT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqPipe,
  input  logic              sbEnable,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [3:0]        reqCmd,
  input  logic              cplValid,
  input  logic [CNT_W-1:0]  cnt,
  output chkStrobes_t       st
);
  logic full;
  logic cmdOk;
  logic highBits;

  assign full     = (cnt == CNT_W'(MAX_OUT));
  assign cmdOk    = isLegalCmd(reqCmd);
  assign highBits = |reqAddr[ADDR_W-1:LEGAL_W];

  always_comb begin
    st = '0;
    st.errSet[ERR_MODE] = reqValid && reqPipe && sbEnable;
    st.errSet[ERR_ADDR] = reqValid && highBits;
    st.errSet[ERR_OVF]  = reqValid && full;
    st.errSet[ERR_CMD]  = reqValid && !cmdOk;
    st.accept = reqValid && !full && cmdOk;
    st.retire = cplValid && (cnt != '0);
  end

  // R3: never accept into a full queue
  a_r3_no_accept_full: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == CNT_W'(MAX_OUT)) |-> !st.accept);

  // R6: no retire on an empty queue
  a_r6_no_retire_empty: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == '0) |-> !st.retire);
endmodule

// File: rtl/agp_chk_dp.sv
module agp_chk_dp
  import agp_chk_pkg::*;
#(
  parameter int MAX_OUT = 16,
  localparam int CNT_W  = $clog2(MAX_OUT + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  chkStrobes_t        st,
  input  logic [NUM_ERR-1:0] clrErr,
  output logic [CNT_W-1:0]   cnt,
  output logic [NUM_ERR-1:0] errFlags
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else begin
      case ({st.accept, st.retire})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_ERR; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN) errFlags[i] <= 1'b0;
      else       errFlags[i] <= st.errSet[i] | (errFlags[i] & ~clrErr[i]);
    end

    // R7: a flag holds until its clear bit is written
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rstN)
      (errFlags[i] && !clrErr[i]) |=> errFlags[i]);
  end

  // R5: count moves by one per accept or retire
  a_r5_inc: assert property (@(posedge clk) disable iff (!rstN)
    (st.accept && !st.retire) |=> cnt == $past(cnt) + 1'b1);
  a_r5_dec: assert property (@(posedge clk) disable iff (!rstN)
    (!st.accept && st.retire) |=> cnt == $past(cnt) - 1'b1);
  a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
    (st.accept == st.retire) |=> $stable(cnt));
  // R3: count never exceeds the limit
  a_r3_bound: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_W'(MAX_OUT));
endmodule

// File: rtl/agp_req_checker.sv
module agp_req_checker
  import agp_chk_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int LEGAL_W = 40,
  parameter int MAX_OUT = 16,
  localparam int CNT_W  = $clog2(MAX_OUT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqPipe,
  input  logic              sbEnable,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [3:0]        reqCmd,
  input  logic              cplValid,
  input  logic [NUM_ERR-1:0] clrErr,
  output logic              reqAccept,
  output logic [CNT_W-1:0]  outstanding,
  output logic              errModeMix,
  output logic              errAddr,
  output logic              errOverflow,
  output logic              errIllegalCmd
);
  chkStrobes_t        st;
  logic [NUM_ERR-1:0] flags;

  agp_chk_ctrl #(.ADDR_W(ADDR_W), .LEGAL_W(LEGAL_W), .MAX_OUT(MAX_OUT)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqPipe(reqPipe),
    .sbEnable(sbEnable), .reqAddr(reqAddr), .reqCmd(reqCmd),
    .cplValid(cplValid), .cnt(outstanding), .st(st)
  );

  agp_chk_dp #(.MAX_OUT(MAX_OUT)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .clrErr(clrErr),
    .cnt(outstanding), .errFlags(flags)
  );

  assign reqAccept     = st.accept;
  assign errModeMix    = flags[ERR_MODE];
  assign errAddr       = flags[ERR_ADDR];
  assign errOverflow   = flags[ERR_OVF];
  assign errIllegalCmd = flags[ERR_CMD];

  // R8: an accepted request always had its strobe high
  a_r8_accept_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    reqAccept |-> reqValid);
endmodule

// File: tb/agp_req_checker_tb.sv
module agp_req_checker_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqPipe = 1'b0, sbEnable = 1'b0, cplValid = 1'b0;
  logic [63:0] reqAddr = '0;
  logic [3:0]  reqCmd = '0, clrErr = '0;
  logic        reqAccept, errModeMix, errAddr, errOverflow, errIllegalCmd;
  logic [4:0]  outstanding;

  int checks = 0, errors = 0;
  int expCnt = 0;
  logic accNow;

  always #2.5 clk = ~clk;

  agp_req_checker u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqPipe(reqPipe),
    .sbEnable(sbEnable), .reqAddr(reqAddr), .reqCmd(reqCmd),
    .cplValid(cplValid), .clrErr(clrErr), .reqAccept(reqAccept),
    .outstanding(outstanding), .errModeMix(errModeMix), .errAddr(errAddr),
    .errOverflow(errOverflow), .errIllegalCmd(errIllegalCmd)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle of stimulus; returns just after the capturing edge
  task automatic cyc(input logic v, input logic pipe, input logic sb,
                     input logic [63:0] addr, input logic [3:0] cmd,
                     input logic cpl, input logic [3:0] clr);
    @(negedge clk);
    reqValid = v; reqPipe = pipe; sbEnable = sb; reqAddr = addr;
    reqCmd = cmd; cplValid = cpl; clrErr = clr;
    #1 accNow = reqAccept;
    @(posedge clk);
    #1;
    reqValid = 0; reqPipe = 0; cplValid = 0; clrErr = '0; reqCmd = '0; reqAddr = '0;
  endtask

  function automatic logic [3:0] flagsNow();
    return {errIllegalCmd, errOverflow, errAddr, errModeMix};
  endfunction

  task automatic testReset();
    check("R9 flags", flagsNow(), 4'h0);
    check("R9 count", outstanding, 0);
  endtask

  task automatic testModeMix();
    cyc(1, 1, 0, 0, 4'h0, 0, 0); expCnt++;
    check("R1 pipe sb off", errModeMix, 0);
    cyc(1, 0, 1, 0, 4'h4, 0, 0); expCnt++;
    check("R1 sideband req", errModeMix, 0);
    cyc(1, 1, 1, 0, 4'h1, 0, 0); expCnt++;
    check("R8 accept with modemix", accNow, 1);
    check("R1 mix set", errModeMix, 1);
    check("R8 counted", outstanding, expCnt);
    cyc(0, 0, 0, 0, 0, 0, 4'b0001);
    check("R7 clear modemix", errModeMix, 0);
  endtask

  task automatic testAddr();
    cyc(1, 0, 0, 64'h0000_00FF_FFFF_FFFF, 4'h5, 0, 0); expCnt++;
    check("R2 below bit40", errAddr, 0);
    cyc(1, 0, 0, 64'h0000_0100_0000_0000, 4'h0, 0, 0); expCnt++;
    check("R8 accept with addr err", accNow, 1);
    check("R2 bit40", errAddr, 1);
    cyc(0, 0, 0, 0, 0, 0, 4'b1101);
    check("R7 other clears leave addr", errAddr, 1);
    cyc(0, 0, 0, 0, 0, 0, 4'b0010);
    check("R7 clear addr", errAddr, 0);
    cyc(1, 0, 0, 64'h8000_0000_0000_0000, 4'h0, 0, 0); expCnt++;
    check("R2 bit63", errAddr, 1);
    check("R5 count", outstanding, expCnt);
    cyc(0, 0, 0, 0, 0, 0, 4'b0010);
  endtask

  task automatic testCmd();
    cyc(1, 0, 0, 0, 4'h2, 0, 0);
    check("R4 refuse", accNow, 0);
    check("R4 flag", errIllegalCmd, 1);
    check("R4 count unchanged", outstanding, expCnt);
    cyc(1, 0, 0, 0, 4'hF, 0, 4'b1000);
    check("R7 set wins over clear", errIllegalCmd, 1);
    cyc(0, 0, 0, 0, 0, 0, 4'b1000);
    check("R7 clear cmd", errIllegalCmd, 0);
    cyc(1, 0, 0, 0, 4'h4, 0, 0); expCnt++;
    check("R4 legal write", errIllegalCmd, 0);
    check("R4 legal accepted", outstanding, expCnt);
  endtask

  task automatic testFillDrain();
    while (expCnt < 16) begin
      cyc(1, 0, 0, 0, 4'h0, 0, 0); expCnt++;
    end
    check("R5 full count", outstanding, 16);
    check("R3 no flag at fill", errOverflow, 0);
    cyc(1, 0, 0, 0, 4'h0, 0, 0);
    check("R3 refuse at full", accNow, 0);
    check("R3 overflow flag", errOverflow, 1);
    check("R3 count held", outstanding, 16);
    cyc(1, 0, 0, 0, 4'h1, 1, 4'b0100); expCnt--;
    check("R3 refuse with cpl", accNow, 0);
    check("R3 cpl retires", outstanding, expCnt);
    check("R7 overflow set wins", errOverflow, 1);
    cyc(1, 0, 0, 0, 4'h5, 1, 0);
    check("R5 both accept", accNow, 1);
    check("R5 both hold", outstanding, expCnt);
    while (expCnt > 0) begin
      cyc(0, 0, 0, 0, 0, 1, 0); expCnt--;
    end
    check("R5 drained", outstanding, 0);
    cyc(0, 0, 0, 0, 0, 1, 0);
    check("R6 empty cpl", outstanding, 0);
    cyc(1, 0, 0, 0, 4'h0, 1, 0); expCnt++;
    check("R6 req+cpl at empty", outstanding, expCnt);
    cyc(0, 0, 0, 0, 0, 0, 4'b0100);
    check("R7 clear overflow", errOverflow, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testModeMix();
    testAddr();
    testCmd();
    testFillDrain();
    check("R9 no stray flags", flagsNow(), 4'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule